// File: doc/BRIEF.md
# Counter Channel Interrupt Combiner

This block sits beside a bank of eight counter channels and merges their events into one shared interrupt request. Every channel offers four event strobes: carry, borrow, compare match and index. A two-bit selector per channel picks which of these can raise that channel's pending flag. A pending flag is set by a rising edge of the selected strobe and stays set until software clears all flags at once. A per-channel mask and a global interrupt-function switch decide whether the pending flags reach the interrupt line.

Software reaches the block through a small 8-bit register bus with combinational reads. The same operation register that turns the interrupt function on and clears the flags can also turn it off and send a one-cycle reset pulse to the counters. The block also holds an active-low register that arms cable-fault detection per channel, shows the active-low fault status of each cable, and shows the live level of each channel's index input.

Top module: `cntr_irq_combiner`

## Requirements
- R1: After reset all pending flags are 0, the mask register is 0, the interrupt function is off, every selector is 0, the cable arm register is 0xFF, `irq_o` is low and `ctr_rst_o` is low.
- R2: Channel n's pending flag is set on the cycle after a rising edge of its selected strobe and then stays set until a clear. The selector codes are 0 carry, 1 compare, 2 carry or borrow, 3 index. Selectors for channels 0 to 3 are at address 3 and for channels 4 to 7 at address 4, with channel k of a register at bits 2k+1:2k.
- R3: A read of address 0 returns the pending flags, bit n for channel n. Writes to address 0 have no effect. Address 7 reads 0.
- R4: A write to address 2 with bit 2 set turns the interrupt function on and clears every pending flag. A strobe edge in the same cycle as the clear wins, and that flag stays set.
- R5: A write to address 2 with bit 0 set sends a pulse of exactly one cycle on `ctr_rst_o`. It also turns the interrupt function off, unless bit 2 is set in the same write. A read of address 2 returns the function state in bit 2 and zeros in every other bit.
- R6: Address 1 holds the mask register. Bit n set lets channel n interrupt. It can be written and read back.
- R7: `irq_o` is high exactly while the function is on and some pending flag has its mask bit set. It follows register state with no extra delay.
- R8: Address 6 is the cable arm register, written active low (a 0 arms channel n). A read returns bit n as 0 only when channel n is armed and its `cable_fault_i` bit is 1. A disarmed channel reads 1.
- R9: A read of address 5 returns `idx_level_i` as it is now. Writes to address 5 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| evt_carry_i | input | 8 | Carry strobe per channel |
| evt_borrow_i | input | 8 | Borrow strobe per channel |
| evt_cmp_i | input | 8 | Compare strobe per channel |
| evt_idx_i | input | 8 | Index strobe per channel |
| idx_level_i | input | 8 | Live index input levels |
| cable_fault_i | input | 8 | Raw cable fault per channel, 1 = fault |
| irq_o | output | 1 | Combined interrupt request |
| ctr_rst_o | output | 1 | One-cycle reset pulse to the counters |

## Verification
The assertions assume that every input is synchronous to `clk` and holds steady across each rising edge. They also assume that the bus drives a defined address and data whenever `bus_wr` is high, and that `bus_wr` stays low during reset. The bench changes every input only on the falling edge and keeps the write strobe low during reset. It drives sparse random strobes so that real rising edges occur. It changes the selectors while strobes are active, and it issues operation writes whose clears often fall in the same cycle as strobe edges.

// File: rtl/cntr_irq_combiner.sv
module cntr_irq_combiner #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic [2:0]     bus_addr,
  input  logic [7:0]     bus_wdata,
  output logic [7:0]     bus_rdata,
  input  logic [NCH-1:0] evt_carry_i,
  input  logic [NCH-1:0] evt_borrow_i,
  input  logic [NCH-1:0] evt_cmp_i,
  input  logic [NCH-1:0] evt_idx_i,
  input  logic [NCH-1:0] idx_level_i,
  input  logic [NCH-1:0] cable_fault_i,
  output logic           irq_o,
  output logic           ctr_rst_o
);
  localparam logic [2:0] A_STAT = 3'd0, A_MASK = 3'd1, A_OP = 3'd2, A_SELLO = 3'd3,
                         A_SELHI = 3'd4, A_LVL = 3'd5, A_CAB = 3'd6;
  localparam int SELW = 2 * NCH;
  localparam int HALF = SELW / 2;

  logic [NCH-1:0]  pend_q, mask_q, prev_q, sel_evt, rise;
  logic [SELW-1:0] src_q;
  logic [NCH-1:0]  cab_q;
  logic            func_q;

  wire op_wr  = bus_wr && bus_addr == A_OP;
  wire clr_wr = op_wr && bus_wdata[2];

  for (genvar c = 0; c < NCH; c++) begin : g_sel
    always_comb begin
      unique case (src_q[2*c +: 2])
        2'd0:    sel_evt[c] = evt_carry_i[c];
        2'd1:    sel_evt[c] = evt_cmp_i[c];
        2'd2:    sel_evt[c] = evt_carry_i[c] | evt_borrow_i[c];
        default: sel_evt[c] = evt_idx_i[c];
      endcase
    end
  end

  assign rise = sel_evt & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= '0;
      prev_q    <= '0;
      mask_q    <= '0;
      src_q     <= '0;
      cab_q     <= '1;
      func_q    <= 1'b0;
      ctr_rst_o <= 1'b0;
    end else begin
      prev_q    <= sel_evt;
      pend_q    <= (clr_wr ? '0 : pend_q) | rise;
      ctr_rst_o <= op_wr && bus_wdata[0];
      if (op_wr) begin
        if (bus_wdata[2])      func_q <= 1'b1;
        else if (bus_wdata[0]) func_q <= 1'b0;
      end
      if (bus_wr) begin
        case (bus_addr)
          A_MASK:  mask_q <= bus_wdata[NCH-1:0];
          A_SELLO: src_q[HALF-1:0] <= bus_wdata;
          A_SELHI: src_q[SELW-1:HALF] <= bus_wdata;
          A_CAB:   cab_q <= bus_wdata[NCH-1:0];
          default: ;
        endcase
      end
    end
  end

  assign irq_o = func_q && |(pend_q & mask_q);

  always_comb begin
    case (bus_addr)
      A_STAT:  bus_rdata = pend_q;
      A_MASK:  bus_rdata = mask_q;
      A_OP:    bus_rdata = {5'b0, func_q, 2'b0};
      A_SELLO: bus_rdata = src_q[HALF-1:0];
      A_SELHI: bus_rdata = src_q[SELW-1:HALF];
      A_LVL:   bus_rdata = idx_level_i;
      A_CAB:   bus_rdata = cab_q | ~cable_fault_i;
      default: bus_rdata = 8'h00;
    endcase
  end

  assert_edge_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> (($past(rise) & ~pend_q) == '0));

  assert_flags_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> (($past(pend_q) & ~pend_q) == '0));

  assert_clear_keeps_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((pend_q & ~$past(rise)) == '0));

  assert_off_pulses_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_wr && bus_wdata[0] && !bus_wdata[2]) |=> (!irq_o && ctr_rst_o));

  assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctr_rst_o && !op_wr) |=> !ctr_rst_o);

  assert_disarmed_reads_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_CAB && cab_q == '1) |-> bus_rdata == 8'hFF);
endmodule

// File: tb/test_cntr_irq_combiner.sv
module test_cntr_irq_combiner;
  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [7:0] evt_carry_i = '0, evt_borrow_i = '0, evt_cmp_i = '0, evt_idx_i = '0;
  logic [7:0] idx_level_i = '0, cable_fault_i = '0;
  logic irq_o, ctr_rst_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0, ev_on = 0;

  bit [7:0]  m_pend, m_mask, m_prev, m_cab, sel, rise;
  bit [15:0] m_src;
  bit        m_func, m_crst;

  always #10 clk = ~clk;

  cntr_irq_combiner i_cntr_irq_combiner (.*);

  function automatic string tag(input bit [2:0] a);
    case (a)
      3'd0: return "R2 R3 R4";
      3'd1: return "R6";
      3'd2: return "R5";
      3'd3, 3'd4: return "R2";
      3'd5: return "R9";
      3'd6: return "R8";
      default: return "R3";
    endcase
  endfunction

  function automatic bit [7:0] exp_rd(input bit [2:0] a);
    case (a)
      3'd0: return m_pend;
      3'd1: return m_mask;
      3'd2: return {5'b0, m_func, 2'b0};
      3'd3: return m_src[7:0];
      3'd4: return m_src[15:8];
      3'd5: return idx_level_i;
      3'd6: return m_cab | ~cable_fault_i;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = 0; m_mask = 0; m_prev = 0; m_cab = 8'hFF; m_src = 0; m_func = 0; m_crst = 0;
    end else begin
      for (int c = 0; c < 8; c++) begin
        int code = m_src[2*c +: 2];
        if (code == 0)      sel[c] = evt_carry_i[c];
        else if (code == 1) sel[c] = evt_cmp_i[c];
        else if (code == 2) sel[c] = evt_carry_i[c] | evt_borrow_i[c];
        else                sel[c] = evt_idx_i[c];
      end
      rise = sel & ~m_prev;
      m_prev = sel;
      m_crst = bus_wr && bus_addr == 2 && bus_wdata[0];
      if (bus_wr && bus_addr == 2 && bus_wdata[2]) m_pend = 0;
      m_pend = m_pend | rise;
      if (bus_wr) begin
        case (bus_addr)
          3'd1: m_mask = bus_wdata;
          3'd2: if (bus_wdata[2]) m_func = 1; else if (bus_wdata[0]) m_func = 0;
          3'd3: m_src[7:0] = bus_wdata;
          3'd4: m_src[15:8] = bus_wdata;
          3'd6: m_cab = bus_wdata;
          default: ;
        endcase
      end
    end
    #5;
    begin
      bit exp_irq;
      bit [7:0] er;
      string t;
      exp_irq = m_func && ((m_pend & m_mask) != 0);
      er = exp_rd(bus_addr);
      n_cmp += 3;
      if (irq_o !== exp_irq) begin
        n_bad++;
        $display("FAIL %s irq_o got %0b exp %0b", rst_n ? "R7" : "R1", irq_o, exp_irq);
      end
      if (ctr_rst_o !== m_crst) begin
        n_bad++;
        $display("FAIL %s ctr_rst_o got %0b exp %0b", rst_n ? "R5" : "R1", ctr_rst_o, m_crst);
      end
      t = rst_n ? tag(bus_addr) : "R1";
      if (bus_rdata !== er) begin
        n_bad++;
        $display("FAIL %s rdata addr %0d got %h exp %h", t, bus_addr, bus_rdata, er);
      end
    end
  end

  always @(negedge clk) begin
    if (ev_on) begin
      evt_carry_i  <= 8'($urandom) & 8'($urandom);
      evt_borrow_i <= 8'($urandom) & 8'($urandom);
      evt_cmp_i    <= 8'($urandom) & 8'($urandom);
      evt_idx_i    <= 8'($urandom) & 8'($urandom);
      if ($urandom_range(7) == 0) idx_level_i   <= 8'($urandom);
      if ($urandom_range(7) == 0) cable_fault_i <= 8'($urandom);
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus_wr   <= 1'b0;
      bus_addr <= 3'($urandom);
    end
  endtask

  task automatic wr(input bit [2:0] a, input bit [7:0] d);
    @(negedge clk);
    bus_wr <= 1'b1; bus_addr <= a; bus_wdata <= d;
    @(negedge clk);
    bus_wr <= 1'b0; bus_addr <= a; bus_wdata <= 8'($urandom);
  endtask

  initial begin
    // R1: reset values checked on every cycle while rst_n is low
    idle(3);
    @(negedge clk); rst_n <= 1'b1;
    ev_on = 1;
    // R2 R7: flags latch while the function is off, so no interrupt
    idle(40);
    // R6: mask, then R4: enable and clear
    wr(3'd1, 8'hFF);
    wr(3'd2, 8'h04);
    idle(30);
    // R3 R9: writes to read-only addresses are ignored
    wr(3'd0, 8'hFF);
    wr(3'd5, 8'h00);
    wr(3'd7, 8'hFF);
    // R8: arm selected channels
    wr(3'd6, 8'h0F);
    idle(20);
    for (int k = 0; k < 400; k++) begin
      int pick = $urandom_range(9);
      case (pick)
        0: wr(3'd3, 8'($urandom));            // R2 selectors low
        1: wr(3'd4, 8'($urandom));            // R2 selectors high
        2: wr(3'd2, 8'h04);                   // R4 clear during edges
        3: wr(3'd2, 8'h01);                   // R5 off and pulse
        4: wr(3'd2, 8'h05);                   // R5 with R4 together
        5: wr(3'd1, 8'($urandom));            // R6
        6: wr(3'd6, 8'($urandom));            // R8
        7: wr(3'($urandom), 8'($urandom));    // R3 R9 any address
        default: idle($urandom_range(1, 6));
      endcase
      idle($urandom_range(0, 3));
    end
    wr(3'd6, 8'hFF);
    idle(10);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog got hang exp completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule